// File: doc/BRIEF.md
# Dual M/N Divider Set Selector with Slewed Retargeting

This block keeps two programmable pairs of PLL divider values, a 6-bit reference divider (M) and a 7-bit feedback divider (N), and decides which pair drives the PLL. The active pair is chosen either by a hardware select pin or by a software bit, depending on a mode bit. The M of the chosen pair is applied at once. The N is walked from its current value toward the chosen target one count at a time, so the loop retargets smoothly instead of jumping.

Register writes arrive as single-cycle pulses from a serial slave, carrying an index and a data byte. An N byte is only staged when it is written. It takes effect together with its partner M byte when that M byte is written, so the PLL never sees a new N paired with an old M. Each single-count step waits a programmable number of step ticks. A lock flag is high whenever the effective N equals the selected target.

Top module: `divset_slewer`

## Requirements
- R1: While reset is held and at its release, the set-0 defaults are N=43, M=49 and the set-1 defaults are N=86, M=49. The pin selects the set, the effective N and M equal the defaults of the set the pin picks, `locked`=1 and `out_div3`=1.
- R2: A write to index 1 (set 0) or index 3 (set 1) stages data bits [6:0] as a pending N and changes no output. A later write to index 2 (set 0) or index 4 (set 1) stores data bits [5:0] as that set's M and releases the staged N as its target, both in the same cycle.
- R3: A write to index 6 stores bit 7 as the mode and bit 6 as the software select. With mode 1, `sel_eff` follows `sel_pin`. With mode 0, `sel_eff` equals the software select bit. `sel_eff`=0 means set 0.
- R4: `m_eff` is always the M of the set named by `sel_eff`, with no stepping.
- R5: `n_eff` changes by exactly one count per step, always toward the current target, and never passes it.
- R6: A step happens after a dwell of DWELL_LONG cycles with `step_tick` high when index 7 bit 7 is 1 (the reset value), or DWELL_SHORT such cycles when it is 0. With `step_tick` low, `n_eff` holds.
- R7: `locked` is 0 exactly while `n_eff` differs from the selected target. When the target changes during a walk, the walk continues from the present `n_eff` toward the new target.
- R8: Index 4 bit 6 sets `out_div3` (0 = divide by 2, 1 = divide by 3), and the same write also updates M1.
- R9: Writes to indices 0 and 5 change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Single-cycle register write pulse |
| wr_idx | input | 3 | Register index of the write |
| wr_data | input | 8 | Register write data |
| sel_pin | input | 1 | Hardware set select |
| step_tick | input | 1 | Enable for the dwell counter |
| m_eff | output | 6 | Effective reference divider |
| n_eff | output | 7 | Effective feedback divider |
| locked | output | 1 | High when n_eff equals the selected target |
| sel_eff | output | 1 | Set currently selected |
| out_div3 | output | 1 | Output divider select, 1 = divide by 3 |

## Verification
The assertions assume three things: reset is held for at least two clock edges, the select pin stays steady while reset is held, and every write is a single-cycle pulse. Under these conditions, any change of `n_eff` is a single count toward the previous target, follows a tick, and never happens while locked. The bench drives reset once with the pin fixed, and each write lasts one cycle between falling edges. The random phase draws its indices, data and pin toggles with `$urandom`, always within that envelope, and waits for lock before each comparison.

// File: rtl/divset_slewer.sv
module divset_slewer #(
  parameter int NW = 7,
  parameter int MW = 6,
  parameter int DWELL_LONG = 2048,
  parameter int DWELL_SHORT = 1024,
  parameter logic [NW-1:0] N0_RST = NW'(43),
  parameter logic [NW-1:0] N1_RST = NW'(86),
  parameter logic [MW-1:0] M0_RST = MW'(49),
  parameter logic [MW-1:0] M1_RST = MW'(49)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_idx,
  input  logic [7:0]    wr_data,
  input  logic          sel_pin,
  input  logic          step_tick,
  output logic [MW-1:0] m_eff,
  output logic [NW-1:0] n_eff,
  output logic          locked,
  output logic          sel_eff,
  output logic          out_div3
);
  localparam int CW = $clog2(DWELL_LONG + 1);

  logic [NW-1:0] n_hold0, n_hold1, n_cfg0, n_cfg1, n_tgt, n_cur;
  logic [MW-1:0] m_cfg0, m_cfg1;
  logic          hw_mode, sw_sel, long_dwell, div3_q;
  logic [CW-1:0] cnt, dwell_last;

  assign sel_eff    = hw_mode ? sel_pin : sw_sel;
  assign n_tgt      = sel_eff ? n_cfg1 : n_cfg0;
  assign m_eff      = sel_eff ? m_cfg1 : m_cfg0;
  assign n_eff      = n_cur;
  assign locked     = (n_cur == n_tgt);
  assign out_div3   = div3_q;
  assign dwell_last = long_dwell ? CW'(DWELL_LONG - 1) : CW'(DWELL_SHORT - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      n_hold0    <= N0_RST;
      n_hold1    <= N1_RST;
      n_cfg0     <= N0_RST;
      n_cfg1     <= N1_RST;
      m_cfg0     <= M0_RST;
      m_cfg1     <= M1_RST;
      hw_mode    <= 1'b1;
      sw_sel     <= 1'b1;
      long_dwell <= 1'b1;
      div3_q     <= 1'b1;
    end else if (wr_en) begin
      case (wr_idx)
        3'd1: n_hold0 <= wr_data[NW-1:0];
        3'd2: begin
          m_cfg0 <= wr_data[MW-1:0];
          n_cfg0 <= n_hold0;
        end
        3'd3: n_hold1 <= wr_data[NW-1:0];
        3'd4: begin
          m_cfg1 <= wr_data[MW-1:0];
          n_cfg1 <= n_hold1;
          div3_q <= wr_data[6];
        end
        3'd6: begin
          hw_mode <= wr_data[7];
          sw_sel  <= wr_data[6];
        end
        3'd7: long_dwell <= wr_data[7];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      n_cur <= sel_pin ? N1_RST : N0_RST;
      cnt   <= '0;
    end else if (locked) begin
      cnt <= '0;
    end else if (step_tick) begin
      if (cnt >= dwell_last) begin
        cnt   <= '0;
        n_cur <= (n_cur < n_tgt) ? n_cur + NW'(1) : n_cur - NW'(1);
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end
endmodule

module divset_slewer_chk #(
  parameter int NW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          step_tick,
  input logic [NW-1:0] n_eff,
  input logic [NW-1:0] n_tgt,
  input logic          locked
);
  p_reset_lock_r1: assert property (@(posedge clk) $rose(rst_n) |-> locked)
    else $error("p_reset_lock_r1");

  p_step_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(n_eff) |-> (n_eff == $past(n_eff) + NW'(1)) || (n_eff == $past(n_eff) - NW'(1)))
    else $error("p_step_one_r5");

  p_toward_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(n_eff) |-> ((n_eff > $past(n_eff)) == ($past(n_tgt) > $past(n_eff))))
    else $error("p_toward_r5");

  p_tick_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(n_eff) |-> $past(step_tick))
    else $error("p_tick_gate_r6");

  p_hold_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(n_eff))
    else $error("p_hold_locked_r7");
endmodule

bind divset_slewer divset_slewer_chk #(.NW(NW)) u_chk (
  .clk(clk), .rst_n(rst_n), .step_tick(step_tick),
  .n_eff(n_eff), .n_tgt(n_tgt), .locked(locked)
);

// File: tb/divset_slewer_test.sv
module divset_slewer_test;
  localparam int DL = 8;
  localparam int DS = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_idx = '0;
  logic [7:0] wr_data = '0;
  logic       sel_pin = 1'b0;
  logic       step_tick = 1'b1;
  logic [5:0] m_eff;
  logic [6:0] n_eff;
  logic       locked, sel_eff, out_div3;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  int hold[2], ncfg[2], mcfg[2];
  bit hw = 1, sw = 1, dlong = 1, div3 = 1;

  divset_slewer #(.DWELL_LONG(DL), .DWELL_SHORT(DS)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .sel_pin(sel_pin), .step_tick(step_tick), .m_eff(m_eff), .n_eff(n_eff),
    .locked(locked), .sel_eff(sel_eff), .out_div3(out_div3)
  );

  always #10 clk = ~clk;

  function automatic int exp_sel();
    return hw ? int'(sel_pin) : int'(sw);
  endfunction

  function automatic int exp_cycles(int from, int to, bit lng);
    int d = (from > to) ? from - to : to - from;
    return d * (lng ? DL : DS);
  endfunction

  task automatic check(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(int idx, int data);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 3'(idx); wr_data = 8'(data);
    @(negedge clk);
    wr_en = 1'b0;
    case (idx)
      1: hold[0] = data & 127;
      2: begin mcfg[0] = data & 63; ncfg[0] = hold[0]; end
      3: hold[1] = data & 127;
      4: begin mcfg[1] = data & 63; ncfg[1] = hold[1]; div3 = data[6]; end
      6: begin hw = data[7]; sw = data[6]; end
      7: dlong = data[7];
      default: ;
    endcase
  endtask

  task automatic wait_lock(output int cyc);
    cyc = 0;
    while (!locked && cyc < 5000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic check_all(string tag);
    check({tag, " R4 m_eff"}, m_eff, mcfg[exp_sel()]);
    check({tag, " R3 sel_eff"}, sel_eff, exp_sel());
    check({tag, " R7 n_eff at lock"}, n_eff, ncfg[exp_sel()]);
    check({tag, " R7 locked"}, locked, 1);
    check({tag, " R8 out_div3"}, out_div3, div3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int cyc, n0, a, b;
    void'($urandom(32'd2024));
    hold[0] = 43; ncfg[0] = 43; mcfg[0] = 49;
    hold[1] = 86; ncfg[1] = 86; mcfg[1] = 49;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 n_eff", n_eff, 43);
    check("R1 m_eff", m_eff, 49);
    check("R1 locked", locked, 1);
    check("R1 out_div3", out_div3, 1);
    check("R1 sel_eff", sel_eff, 0);

    wr(1, 50);
    repeat (20) @(negedge clk);
    check("R2 staged N not applied", n_eff, 43);
    check("R2 staged N locked", locked, 1);
    wr(2, 40);
    check("R2 M applied", m_eff, 40);
    check("R7 lock drops", locked, 0);
    wait_lock(cyc);
    check("R6 long dwell cycles", cyc, exp_cycles(43, 50, 1));
    check("R2 N applied", n_eff, 50);

    @(negedge clk); sel_pin = 1'b1; #1;
    check("R3 pin select", sel_eff, 1);
    check("R4 M immediate", m_eff, 49);
    check("R7 unlocked on switch", locked, 0);
    wait_lock(cyc);
    check("R5 walk to set1", cyc, exp_cycles(50, 86, 1));
    check("R5 n_eff set1", n_eff, 86);

    wr(6, 8'h00);
    check("R3 sw select 0", sel_eff, 0);
    repeat (20) @(negedge clk);
    n0 = n_eff;
    check("R5 partial walk", n0, 86 - 2);
    wr(6, 8'h40);
    wait_lock(cyc);
    check("R7 retarget continues", n_eff, 86);
    check("R7 retarget cycles", cyc <= exp_cycles(n0, 86, 1) ? 1 : 0, 1);

    wr(7, 8'h00);
    wr(3, 60);
    wr(4, 8'h31);
    check("R8 div2 select", out_div3, 0);
    wait_lock(cyc);
    check("R6 short dwell cycles", cyc, exp_cycles(86, 60, 0));
    check("R6 n_eff short", n_eff, 60);

    step_tick = 1'b0;
    wr(3, 70);
    wr(4, 8'h71);
    check("R8 div3 select", out_div3, 1);
    repeat (30) @(negedge clk);
    check("R6 no tick holds", n_eff, 60);
    step_tick = 1'b1;
    wait_lock(cyc);
    check("R6 resumes", n_eff, 70);

    wr(0, 8'hFF);
    wr(5, 8'hFF);
    repeat (5) @(negedge clk);
    check("R9 ignored n", n_eff, 70);
    check("R9 ignored m", m_eff, 49);
    check("R9 ignored lock", locked, 1);
    check("R9 ignored div", out_div3, 1);
    check("R9 ignored sel", sel_eff, 1);

    for (int i = 0; i < 40; i++) begin
      a = int'($urandom_range(0, 5));
      b = int'($urandom_range(0, 255));
      case (a)
        0: wr(1, b);
        1: wr(2, b);
        2: wr(3, b);
        3: wr(4, b);
        4: wr(6, b);
        default: begin
          if (b[0]) wr(7, b);
          else begin @(negedge clk); sel_pin = ~sel_pin; end
        end
      endcase
      if (i % 4 == 3) begin
        wait_lock(cyc);
        @(negedge clk);
        check_all($sformatf("rand %0d", i));
      end
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule